// File: doc/BRIEF.md
# Narrow-Bus Byte-Lane Access Sequencer

This block sits between a 32-bit load/store path and an external bus whose data width is 8, 16 or 32 bits, chosen per access. An access is a word address, a four-bit byte mask, a direction and, for writes, a data word. The block splits it into as many external bus cycles as the configured width requires. It issues a cycle only for a byte or halfword that holds at least one selected byte, and it issues them from the lowest address upward.

For each cycle the block drives four lane-select pins. Their meaning depends on the width. On a 32-bit bus they are four byte enables. On a 16-bit bus they carry a high-byte enable, address bit 1 and a low-byte enable. On an 8-bit bus they carry address bits 1 and 0. Write data is shifted down onto the low lanes. Read data returned on the low lanes is put back into its place in the 32-bit word.

A bus cycle engine runs each external cycle. The two sides use a request/done handshake per cycle. The requester sees a single-cycle response pulse that carries the assembled read word.

Top module: `nls_seq`

## Requirements
- R1: After reset `acc_ready` is 1 and both `cyc_req` and `rsp_valid` are 0. An access is taken on a clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` stays low from that edge until the edge that sets `rsp_valid`.
- R2: `acc_width` is encoded as 0 for an 8-bit bus, 1 for a 16-bit bus, 2 for a 32-bit bus, and 3 is handled as 32-bit. The number of bus cycles equals the number of needed units: a unit is a byte on an 8-bit bus, a halfword on a 16-bit bus, or the whole word on a 32-bit bus, and it is needed when it holds at least one selected byte.
- R3: On a 32-bit bus, `bus_be[i]` equals mask bit i, so that pin 3 selects data bits 31:24 and pin 0 selects bits 7:0. `bus_wdata` is the full write word.
- R4: On a 16-bit bus, halfword u has pin 3 equal to mask bit 2u+1 (the high-byte enable), pin 2 equal to 0, pin 1 equal to u (address bit 1) and pin 0 equal to mask bit 2u (the low-byte enable). `bus_wdata` is halfword u in bits 15:0 with zeros above.
- R5: On an 8-bit bus, byte u has pins 3 and 2 at 0 and pins 1:0 equal to u (address bits 1:0). `bus_wdata` is byte u in bits 7:0 with zeros above.
- R6: An access with an all-zero mask starts no bus cycle. It raises `rsp_valid` at its accept edge, and `rsp_rdata` is 0.
- R7: `cyc_req` stays high, and `bus_be`, `bus_addr`, `bus_wr` and `bus_wdata` stay unchanged, until the engine raises `cyc_done`. Any number of wait cycles is allowed.
- R8: The cycles of one access run in ascending unit order. `bus_addr` equals the access word address and `bus_wr` equals the access direction in every cycle.
- R9: On a read, each selected byte of `rsp_rdata` comes from its unit's returned low lanes, and each unselected byte is 0. Lanes above the bus width are ignored.
- R10: `rsp_valid` is a one-cycle pulse. It rises at the edge where `cyc_done` ends the last needed cycle, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Block idle, access can be taken |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_width | input | 2 | Bus width code of the region |
| acc_addr | input | ADDR_W | Word address |
| acc_mask | input | 4 | Byte-select mask, bit i = byte i |
| acc_wdata | input | 32 | Write word |
| cyc_req | output | 1 | Bus cycle request to the engine |
| cyc_done | input | 1 | Engine ends the current cycle |
| bus_addr | output | ADDR_W | Word address of the cycle |
| bus_be | output | 4 | Width-dependent lane-select pins |
| bus_wr | output | 1 | Cycle direction, 1 = write |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Returned data, low lanes used |
| rsp_valid | output | 1 | Access complete pulse |
| rsp_rdata | output | 32 | Assembled read word |

## Verification
The bench builds the block with `ADDR_W` set to 12. This shows that the word address passes through every cycle of a split access without change. The bus engine model is run with zero and with two wait cycles per bus cycle, so request hold under stalls is checked next to the back-to-back case. The model fills the lanes above the bus width with a fixed junk pattern, so any read merge that uses an upper lane shows up as a wrong byte. Sparse masks such as a single high byte or alternating bytes check the skip rule and the lane-select encoding on every width.

// File: rtl/nls_pkg.sv
// Shared types for the narrow-bus lane sequencer.
// Assumes a four-lane (32-bit) internal word.
package nls_pkg;
    typedef enum logic [1:0] {
        BW_8   = 2'd0,
        BW_16  = 2'd1,
        BW_32  = 2'd2,
        BW_RSV = 2'd3
    } bus_width_e;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
endpackage

// File: rtl/nls_unit_plan.sv
// Decides which transfer units of an access need a bus cycle.
// A unit is a byte (8-bit bus), a halfword (16-bit bus) or the word.
// A unit is needed when it holds a selected byte. Assumes LANES = 4.
module nls_unit_plan
    import nls_pkg::*;
(
    input  bus_width_e         width,
    input  logic [LANES-1:0]   mask,
    output logic [LANES-1:0]   need
);
    localparam int HALVES = LANES / 2;

    logic [HALVES-1:0] half_any;

    // OR-reduce the mask per halfword.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_any[h] = mask[2*h] | mask[2*h+1];
    end

    // Choose the unit map for the configured width.
    always_comb begin
        need = '0;
        case (width)
            BW_8:    need = mask;
            BW_16:   need[HALVES-1:0] = half_any;
            default: need[0] = |mask;
        endcase
    end
endmodule

// File: rtl/nls_lane_mux.sv
// Builds the lane-select pins and the low-lane write data for one unit.
// Unused pins and lanes are driven to 0. Assumes `unit` is in range for width.
module nls_lane_mux
    import nls_pkg::*;
(
    input  bus_width_e          width,
    input  logic [1:0]          unit,
    input  logic [LANES-1:0]    mask,
    input  logic [WORD_W-1:0]   wdata,
    output logic [LANES-1:0]    be,
    output logic [WORD_W-1:0]   lane_wdata
);
    logic [2*LANE_W-1:0] half_sel;
    logic [LANE_W-1:0]   byte_sel;

    // Pick the halfword and the byte addressed by the unit.
    always_comb begin
        half_sel = unit[0] ? wdata[2*LANE_W +: 2*LANE_W] : wdata[0 +: 2*LANE_W];
        byte_sel = wdata[LANE_W*unit +: LANE_W];
    end

    // Map pins and data for the width.
    always_comb begin
        be         = '0;
        lane_wdata = '0;
        case (width)
            BW_8: begin
                be[1:0]            = unit;
                lane_wdata[LANE_W-1:0] = byte_sel;
            end
            BW_16: begin
                be[3]              = unit[0] ? mask[3] : mask[1];
                be[1]              = unit[0];
                be[0]              = unit[0] ? mask[2] : mask[0];
                lane_wdata[2*LANE_W-1:0] = half_sel;
            end
            default: begin
                be         = mask;
                lane_wdata = wdata;
            end
        endcase
    end
endmodule

// File: rtl/nls_read_merge.sv
// Puts the low lanes returned by one unit into their byte positions.
// Only selected bytes are updated; the others keep their value.
module nls_read_merge
    import nls_pkg::*;
(
    input  bus_width_e          width,
    input  logic [1:0]          unit,
    input  logic [LANES-1:0]    mask,
    input  logic [WORD_W-1:0]   cur,
    input  logic [WORD_W-1:0]   rdata,
    output logic [WORD_W-1:0]   merged
);
    for (genvar b = 0; b < LANES; b++) begin : g_byte
        logic             hit;
        logic [LANE_W-1:0] src;

        // Find whether this unit carries byte b and on which lane.
        always_comb begin
            case (width)
                BW_8: begin
                    hit = (unit == 2'(b));
                    src = rdata[LANE_W-1:0];
                end
                BW_16: begin
                    hit = (unit[0] == 1'(b / 2));
                    src = rdata[LANE_W*(b % 2) +: LANE_W];
                end
                default: begin
                    hit = 1'b1;
                    src = rdata[LANE_W*b +: LANE_W];
                end
            endcase
        end

        assign merged[LANE_W*b +: LANE_W] = (hit && mask[b]) ? src : cur[LANE_W*b +: LANE_W];
    end
endmodule

// File: rtl/nls_seq.sv
// Narrow-bus byte-lane access sequencer, top level.
// Takes one 32-bit access at a time and runs one bus cycle per needed unit,
// lowest unit first, each held until cyc_done. Assumes the engine keeps
// bus_rdata valid in the cycle where cyc_done is high.
module nls_seq
    import nls_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    output logic                 acc_ready,
    input  logic                 acc_write,
    input  logic [1:0]           acc_width,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [3:0]           acc_mask,
    input  logic [31:0]          acc_wdata,
    output logic                 cyc_req,
    input  logic                 cyc_done,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [3:0]           bus_be,
    output logic                 bus_wr,
    output logic [31:0]          bus_wdata,
    input  logic [31:0]          bus_rdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata
);
    logic                busy;
    logic [LANES-1:0]    pend;
    bus_width_e          width_q;
    logic                wr_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [LANES-1:0]    mask_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [WORD_W-1:0]   rdata_q;
    logic                rsp_q;

    logic [LANES-1:0]    need;
    logic [1:0]          unit;
    logic [LANES-1:0]    unit_bit;
    logic [WORD_W-1:0]   merged;
    logic                take;
    logic                last;

    nls_unit_plan u_plan (
        .width (bus_width_e'(acc_width)),
        .mask  (acc_mask),
        .need  (need)
    );

    nls_lane_mux u_mux (
        .width      (width_q),
        .unit       (unit),
        .mask       (mask_q),
        .wdata      (wdata_q),
        .be         (bus_be),
        .lane_wdata (bus_wdata)
    );

    nls_read_merge u_merge (
        .width  (width_q),
        .unit   (unit),
        .mask   (mask_q),
        .cur    (rdata_q),
        .rdata  (bus_rdata),
        .merged (merged)
    );

    // Lowest pending unit is served first.
    always_comb begin
        unit = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) unit = 2'(i);
        end
        unit_bit = LANES'(1) << unit;
    end

    assign take = acc_valid && !busy;
    assign last = (pend & ~unit_bit) == '0;

    // Access state: load on accept, retire one unit per cyc_done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            pend    <= '0;
            width_q <= BW_32;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            if (take) begin
                width_q <= bus_width_e'(acc_width);
                wr_q    <= acc_write;
                addr_q  <= acc_addr;
                mask_q  <= acc_mask;
                wdata_q <= acc_wdata;
                rdata_q <= '0;
                pend    <= need;
                busy    <= (need != '0);
                rsp_q   <= (need == '0);
            end else if (busy && cyc_done) begin
                pend <= pend & ~unit_bit;
                if (!wr_q) rdata_q <= merged;
                if (last) begin
                    busy  <= 1'b0;
                    rsp_q <= 1'b1;
                end
            end
        end
    end

    assign acc_ready = !busy;
    assign cyc_req   = busy;
    assign bus_addr  = addr_q;
    assign bus_wr    = wr_q;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/nls_seq_chk.sv
// Assertion checker for nls_seq, attached by bind below.
// Assumes it sees the top's ports plus its busy flag and latched width.
module nls_seq_chk #(
    parameter int ADDR_W = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_ready,
    input logic              cyc_req,
    input logic              cyc_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              rsp_valid,
    input logic              busy,
    input logic [1:0]        width_q
);
    // R1: no bus cycle is requested while a new access can be taken.
    a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req |-> !acc_ready);

    // R5: 8-bit cycles keep the upper pins and lanes at 0.
    a_r5_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && width_q == 2'd0) |-> (bus_be[3:2] == 2'b00 && bus_wdata[31:8] == '0));

    // R4: 16-bit cycles keep pin 2 and the upper lanes at 0.
    a_r4_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && width_q == 2'd1) |-> (!bus_be[2] && bus_wdata[31:16] == '0));

    // R7: a stalled cycle holds its request and its pins.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && !cyc_done) |=> (cyc_req && $stable(bus_be) && $stable(bus_addr) && $stable(bus_wdata)));

    // R8: 8-bit cycles of one access step upward in address.
    a_r8_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && cyc_done && width_q == 2'd0) |=> (!cyc_req || bus_be[1:0] > $past(bus_be[1:0])));

    // R10: completion after a busy phase follows a cyc_done.
    a_r10_rsp_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(busy)) |-> $past(cyc_done));
endmodule

bind nls_seq nls_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_ready (acc_ready),
    .cyc_req   (cyc_req),
    .cyc_done  (cyc_done),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .width_q   (width_q)
);

// File: tb/sim_nls_seq.sv
`timescale 1ns/1ps
module sim_nls_seq;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_ready;
    logic          acc_write = 1'b0;
    logic [1:0]    acc_width = 2'd2;
    logic [AW-1:0] acc_addr = '0;
    logic [3:0]    acc_mask = '0;
    logic [31:0]   acc_wdata = '0;
    logic          cyc_req;
    logic          cyc_done = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_be;
    logic          bus_wr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;

    int checks = 0;
    int errors = 0;

    // Bus engine model state.
    int          wait_n = 0;
    int          wcnt = 0;
    bit          in_cyc = 0;
    logic [3:0]  be_first;
    logic [31:0] wd_first;
    int          stable_err = 0;
    logic [31:0] mem_word = 32'h0;
    logic [1:0]  cur_w = 2'd2;

    logic [3:0]    lg_be [0:7];
    logic [31:0]   lg_wd [0:7];
    logic [AW-1:0] lg_ad [0:7];
    logic          lg_wr [0:7];
    int            lg_n = 0;

    nls_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
        .acc_width(acc_width), .acc_addr(acc_addr), .acc_mask(acc_mask),
        .acc_wdata(acc_wdata), .cyc_req(cyc_req), .cyc_done(cyc_done),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always #10 clk = ~clk;

    // Returned data: wanted unit on the low lanes, junk above the bus width.
    function automatic logic [31:0] resp_data(input logic [3:0] be);
        case (cur_w)
            2'd0:    return {24'h5A5A5A, mem_word[8*be[1:0] +: 8]};
            2'd1:    return {16'hA5A5, be[1] ? mem_word[31:16] : mem_word[15:0]};
            default: return mem_word;
        endcase
    endfunction

    // Engine model: wait wait_n cycles, then end the cycle and log it.
    always @(negedge clk) begin
        if (cyc_req) begin
            if (!in_cyc) begin
                in_cyc = 1;
                wcnt = 0;
                be_first = bus_be;
                wd_first = bus_wdata;
            end else if (bus_be !== be_first || bus_wdata !== wd_first) begin
                stable_err++;
            end
            if (wcnt >= wait_n) begin
                cyc_done = 1'b1;
                bus_rdata = resp_data(bus_be);
                if (lg_n < 8) begin
                    lg_be[lg_n] = bus_be;
                    lg_wd[lg_n] = bus_wdata;
                    lg_ad[lg_n] = bus_addr;
                    lg_wr[lg_n] = bus_wr;
                end
                lg_n++;
                in_cyc = 0;
            end else begin
                cyc_done = 1'b0;
                wcnt++;
            end
        end else begin
            cyc_done = 1'b0;
            in_cyc = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access: drive, wait for completion, compare every cycle and the result.
    task automatic run_access(input logic [1:0] w, input logic wr, input logic [3:0] mask,
                              input logic [31:0] wd, input logic [AW-1:0] ad, input int waits);
        int          nunits;
        int          k;
        int          lat;
        bit          need;
        logic [3:0]  eb;
        logic [31:0] ew;
        logic [31:0] er;
        @(negedge clk);
        wait_n = waits; stable_err = 0; lg_n = 0; cur_w = w;
        acc_valid = 1'b1; acc_write = wr; acc_width = w; acc_mask = mask;
        acc_wdata = wd; acc_addr = ad;
        @(negedge clk);
        acc_valid = 1'b0;
        if (mask != 4'b0)
            chk(acc_ready == 1'b0, "R1 ready low while busy", 32'(acc_ready), 32'h0);
        lat = 0;
        while (!rsp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(rsp_valid == 1'b1, "R10 completion seen", 32'(rsp_valid), 32'h1);
        if (mask == 4'b0)
            chk(lat == 0, "R6 empty mask completes at accept", 32'(lat), 32'h0);
        er = '0;
        for (int b = 0; b < 4; b++) if (mask[b]) er[8*b +: 8] = mem_word[8*b +: 8];
        if (!wr)
            chk(rsp_rdata == er, "R9 read assembly", rsp_rdata, er);
        else
            chk(rsp_rdata == 32'h0, "R9 write leaves result zero", rsp_rdata, 32'h0);
        nunits = (w == 2'd0) ? 4 : (w == 2'd1) ? 2 : 1;
        k = 0;
        for (int u = 0; u < nunits; u++) begin
            if (w == 2'd0) begin
                need = mask[u];
                eb = {2'b00, 2'(u)};
                ew = {24'h0, wd[8*u +: 8]};
            end else if (w == 2'd1) begin
                need = mask[2*u] | mask[2*u+1];
                eb = {mask[2*u+1], 1'b0, 1'(u), mask[2*u]};
                ew = {16'h0, wd[16*u +: 16]};
            end else begin
                need = |mask;
                eb = mask;
                ew = wd;
            end
            if (need) begin
                if (k < lg_n && k < 8) begin
                    if (w == 2'd0)      chk(lg_be[k] == eb, "R5/R8 pins per byte", 32'(lg_be[k]), 32'(eb));
                    else if (w == 2'd1) chk(lg_be[k] == eb, "R4/R8 pins per halfword", 32'(lg_be[k]), 32'(eb));
                    else                chk(lg_be[k] == eb, "R3 byte enables", 32'(lg_be[k]), 32'(eb));
                    if (wr) chk(lg_wd[k] == ew, "R3/R4/R5 write lanes", lg_wd[k], ew);
                    chk(lg_ad[k] == ad && lg_wr[k] == wr, "R8 address and direction",
                        {lg_wr[k], 19'h0, lg_ad[k]}, {wr, 19'h0, ad});
                end
                k++;
            end
        end
        chk(lg_n == k, "R2 cycle count", 32'(lg_n), 32'(k));
        chk(stable_err == 0, "R7 pins held during wait", 32'(stable_err), 32'h0);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 single-cycle pulse", 32'(rsp_valid), 32'h0);
    endtask

    task automatic t_reset;
        chk(acc_ready == 1'b1, "R1 reset ready", 32'(acc_ready), 32'h1);
        chk(cyc_req == 1'b0, "R1 reset no request", 32'(cyc_req), 32'h0);
        chk(rsp_valid == 1'b0, "R1 reset no response", 32'(rsp_valid), 32'h0);
    endtask

    task automatic t_word_bus;
        mem_word = 32'hCAFE_F00D;
        run_access(2'd2, 1'b1, 4'b1111, 32'h1122_3344, 12'h3A5, 0);
        run_access(2'd2, 1'b0, 4'b0110, 32'h0, 12'h001, 2);
        run_access(2'd3, 1'b0, 4'b1000, 32'h0, 12'h7FF, 0);
    endtask

    task automatic t_half_bus;
        mem_word = 32'h8765_4321;
        run_access(2'd1, 1'b1, 4'b1111, 32'hAABB_CCDD, 12'h010, 0);
        run_access(2'd1, 1'b1, 4'b0100, 32'h1234_5678, 12'h020, 2);
        run_access(2'd1, 1'b0, 4'b1001, 32'h0, 12'h030, 0);
    endtask

    task automatic t_byte_bus;
        mem_word = 32'h0F1E_2D3C;
        run_access(2'd0, 1'b1, 4'b1111, 32'h0102_0304, 12'h100, 0);
        run_access(2'd0, 1'b0, 4'b1010, 32'h0, 12'h200, 2);
        run_access(2'd0, 1'b1, 4'b1000, 32'hDEAD_BEEF, 12'hFFF, 1);
        run_access(2'd0, 1'b0, 4'b1111, 32'h0, 12'h0AA, 0);
    endtask

    task automatic t_empty_mask;
        run_access(2'd0, 1'b0, 4'b0000, 32'h0, 12'h044, 0);
        run_access(2'd1, 1'b1, 4'b0000, 32'hFFFF_FFFF, 12'h055, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_bus();
        t_half_bus();
        t_byte_bus();
        t_empty_mask();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule